// File: doc/BRIEF.md
# Iterative AES-128 Encryption Core

This core turns one 128-bit plaintext block into its AES-128 ciphertext under a 128-bit cipher key. A start strobe captures key and plaintext and performs the initial key whitening in the same edge. The core then runs ten rounds, one per clock. Each round key is derived from the previous one in the cycle that uses it, so only a state register and a round-key register are kept. No table of expanded keys exists.

While an encryption is in progress a busy flag stays high. It can be wired straight to an external measurement trigger. When the last round lands, a one-cycle done pulse marks the ciphertext as valid. The ciphertext then holds until the next accepted start. The host may issue the next start in the cycle that shows done, which gives back-to-back operation every eleven cycles.

Top module: `aes128_iter`

## Requirements
- R1: After reset, busy_o and done_o are 0.
- R2: For key 000102030405060708090a0b0c0d0e0f and plaintext 00112233445566778899aabbccddeeff, ct_o equals 69c4e0d86a7b0430d8cdb78070b4c55a when done_o is high.
- R3: busy_o rises on the clock edge that samples an accepted start and stays high for exactly 10 cycles.
- R4: done_o is high for exactly one cycle, in the cycle where busy_o has just fallen, i.e. 11 edges after the accepted start edge.
- R5: A start_i pulse sampled while busy_o is high has no effect. The running encryption keeps its data and its timing, and no extra done_o pulse appears.
- R6: After done_o, ct_o holds its value until the next accepted start.
- R7: The round-key schedule applies round constants 01,02,04,08,10,20,40,80,1B,36 in rounds 1 to 10, and the last round skips MixColumns. Several distinct key/plaintext vectors must therefore produce their standard ciphertexts (byte 0 of each 128-bit value sits in bits 127:120).
- R8: A start_i sampled in the cycle where done_o is high is accepted, so encryptions can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an encryption when the core is idle |
| key_i | input | 128 | Cipher key, sampled with an accepted start |
| pt_i | input | 128 | Plaintext block, sampled with an accepted start |
| ct_o | output | 128 | Ciphertext (valid from done_o until the next start) |
| busy_o | output | 1 | High for the whole encryption; usable as trigger |
| done_o | output | 1 | One-cycle pulse when ct_o becomes valid |

## Verification
The bench builds the core with its default parameters: 128-bit block and key, and ten rounds. Those are the only values the elaboration checks accept. That setting brings the full round-constant sequence within reach, including the wrap to 1B and 36. It also reaches the final round without MixColumns, which four independent published vectors expose. The same build exercises the exact eleven-edge latency, a start injected mid-run, and starts issued in the done cycle.

// File: rtl/aes_iter_pkg.sv
package aes_iter_pkg;
   localparam int BLK_W = 128;
   typedef logic [7:0]  byte_t;
   typedef logic [31:0] word_t;

   function automatic byte_t xt(byte_t a);
      return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
   endfunction

   function automatic byte_t gmul(byte_t a, byte_t b);
      byte_t p  = 8'h00;
      byte_t aa = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) p = p ^ aa;
         aa = xt(aa);
      end
      return p;
   endfunction

   // inverse as x^254, then the affine map
   function automatic byte_t sbox(byte_t x);
      byte_t sq  = x;
      byte_t inv = 8'h01;
      for (int i = 0; i < 7; i++) begin
         sq  = gmul(sq, sq);
         inv = gmul(inv, sq);
      end
      return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                 ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
   endfunction

   // constant for round n (1-based): doubling in the field
   function automatic byte_t rcon(logic [3:0] n);
      byte_t r = 8'h01;
      for (int i = 1; i < 10; i++)
         if (4'(i) < n) r = xt(r);
      return r;
   endfunction
endpackage

// File: rtl/aes_key_step.sv
module aes_key_step
   import aes_iter_pkg::*;
(
   input  logic [BLK_W-1:0] key_i,
   input  byte_t            rc_i,
   output logic [BLK_W-1:0] key_o
);
   localparam int NW = BLK_W / 32;
   word_t w [NW];
   word_t t;

   for (genvar i = 0; i < NW; i++) begin : g_split
      assign w[i] = key_i[BLK_W-1-32*i -: 32];
   end

   assign t = {sbox(w[NW-1][23:16]) ^ rc_i, sbox(w[NW-1][15:8]),
               sbox(w[NW-1][7:0]), sbox(w[NW-1][31:24])};

   word_t n [NW];
   for (genvar i = 0; i < NW; i++) begin : g_chain
      if (i == 0) begin : g_first
         assign n[i] = w[i] ^ t;
      end else begin : g_rest
         assign n[i] = w[i] ^ n[i-1];
      end
      assign key_o[BLK_W-1-32*i -: 32] = n[i];
   end
endmodule

// File: rtl/aes_round.sv
module aes_round
   import aes_iter_pkg::*;
(
   input  logic [BLK_W-1:0] st_i,
   input  logic [BLK_W-1:0] rk_i,
   input  logic             last_i,
   output logic [BLK_W-1:0] st_o
);
   localparam int NC = 4;
   byte_t sr [NC][4];
   byte_t mc [NC][4];
   logic [BLK_W-1:0] pre;

   for (genvar c = 0; c < NC; c++) begin : g_col
      for (genvar r = 0; r < 4; r++) begin : g_row
         localparam int SRC = 4*((c+r) % NC) + r;
         assign sr[c][r] = sbox(st_i[BLK_W-1-8*SRC -: 8]);
      end
      for (genvar r = 0; r < 4; r++) begin : g_mix
         assign mc[c][r] = xt(sr[c][r]) ^ xt(sr[c][(r+1)%4]) ^ sr[c][(r+1)%4]
                         ^ sr[c][(r+2)%4] ^ sr[c][(r+3)%4];
         assign pre[BLK_W-1-8*(4*c+r) -: 8] = last_i ? sr[c][r] : mc[c][r];
      end
   end

   assign st_o = pre ^ rk_i;
endmodule

// File: rtl/aes_seq_ctrl.sv
module aes_seq_ctrl #(
   parameter int ROUNDS = 10,
   localparam int RW = $clog2(ROUNDS + 1)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          start_i,
   output logic          load_o,
   output logic          step_o,
   output logic          last_o,
   output logic [RW-1:0] round_o,
   output logic          busy_o,
   output logic          done_o
);
   logic [RW-1:0] round_q;
   logic          busy_q, done_q;

   assign load_o  = start_i && !busy_q;
   assign step_o  = busy_q;
   assign last_o  = round_q == RW'(ROUNDS);
   assign round_o = round_q;
   assign busy_o  = busy_q;
   assign done_o  = done_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         round_q <= '0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (load_o) begin
            busy_q  <= 1'b1;
            round_q <= RW'(1);
         end else if (busy_q) begin
            if (last_o) begin
               busy_q  <= 1'b0;
               done_q  <= 1'b1;
               round_q <= '0;
            end else begin
               round_q <= round_q + RW'(1);
            end
         end
      end
   end

   a_r4_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |=> !done_q);
   a_r5_ignore_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q && start_i && !last_o) |=> (busy_q && round_q == $past(round_q) + RW'(1)));
endmodule

// File: rtl/aes128_iter.sv
module aes128_iter
   import aes_iter_pkg::*;
#(
   parameter int KEY_W  = 128,
   parameter int ROUNDS = 10,
   localparam int RW = $clog2(ROUNDS + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic [KEY_W-1:0] key_i,
   input  logic [BLK_W-1:0] pt_i,
   output logic [BLK_W-1:0] ct_o,
   output logic             busy_o,
   output logic             done_o
);
   if (KEY_W != 128) begin : g_bad_key
      $error("aes128_iter: only a 128-bit key is supported");
   end
   if (ROUNDS != 10) begin : g_bad_rounds
      $error("aes128_iter: AES-128 needs exactly 10 rounds");
   end

   logic [BLK_W-1:0] state_q, key_q, key_nx, state_nx;
   logic             load, step, last;
   logic [RW-1:0]    round;

   aes_seq_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
      .clk_i, .rst_ni, .start_i,
      .load_o(load), .step_o(step), .last_o(last), .round_o(round),
      .busy_o, .done_o
   );

   aes_key_step u_kstep (.key_i(key_q), .rc_i(rcon(4'(round))), .key_o(key_nx));

   aes_round u_round (.st_i(state_q), .rk_i(key_nx), .last_i(last), .st_o(state_nx));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= '0;
         key_q   <= '0;
      end else if (load) begin
         state_q <= pt_i ^ key_i;
         key_q   <= key_i;
      end else if (step) begin
         state_q <= state_nx;
         key_q   <= key_nx;
      end
   end

   assign ct_o = state_q;

   // independent busy-length counter for the checks below
   logic [RW:0] busy_len;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      busy_len <= '0;
      else if (busy_o)  busy_len <= busy_len + 1'b1;
      else              busy_len <= '0;
   end

   a_r3_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> $past(busy_len) == (RW+1)'(ROUNDS - 1));
   a_r4_done_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> $fell(busy_o));
   a_r4_fall_gives_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> done_o);
   a_r6_ct_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && !start_i) |=> $stable(ct_o));
   a_r8_accept_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && start_i) |=> busy_o);
endmodule

// File: tb/aes128_iter_tb.sv
module aes128_iter_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [127:0] key = '0, pt = '0;
   logic [127:0] ct;
   logic         busy, done;

   int checks = 0, fails = 0, dones = 0;
   logic [127:0] exp_q [$];
   logic [127:0] last_ct;

   always #10 clk = ~clk;

   aes128_iter u_dut (.clk_i(clk), .rst_ni(rst_n), .start_i(start), .key_i(key),
                      .pt_i(pt), .ct_o(ct), .busy_o(busy), .done_o(done));

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: pop expected ciphertext on each done pulse
   always @(negedge clk) begin
      if (rst_n && done) begin
         dones++;
         if (exp_q.size() == 0) chk(1'b0, "R5 unexpected done", ct, '0);
         else begin
            logic [127:0] e;
            e = exp_q.pop_front();
            chk(ct == e, "R2/R7 ciphertext", ct, e);
         end
      end
   end

   // driver: called at a negedge; returns at the negedge showing done
   task automatic run(input logic [127:0] k, input logic [127:0] p, input logic [127:0] e,
                      input bit poke);
      int n = 0;
      exp_q.push_back(e);
      key = k; pt = p; start = 1'b1;
      @(negedge clk);
      start = 1'b0; key = ~k; pt = ~p;
      while (busy && n < 20) begin
         n++;
         if (poke && n == 3) start = 1'b1;   // R5: start while busy
         @(negedge clk);
         start = 1'b0;
      end
      chk(n == 10, "R3 busy length", 128'(n), 128'd10);
      chk(done == 1'b1, "R4 done at busy fall", 128'(done), 128'd1);
   endtask

   initial begin : watchdog
      #(20 * 5000);
      chk(1'b0, "watchdog", '0, '0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R1 busy after reset", 128'(busy), '0);
      chk(done == 1'b0, "R1 done after reset", 128'(done), '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0, "R1 idle", 128'({busy, done}), '0);

      // R2 reference vector, with an ignored start mid-run (R5)
      run(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff,
          128'h69c4e0d86a7b0430d8cdb78070b4c55a, 1'b1);
      last_ct = ct;
      @(negedge clk);
      chk(done == 1'b0, "R4 done one cycle", 128'(done), '0);
      repeat (4) @(negedge clk);
      chk(ct == last_ct, "R6 ct holds", ct, last_ct);
      chk(busy == 1'b0 && dones == 1, "R5 no extra run", 128'(dones), 128'd1);

      // R7 / R8: back-to-back vectors, each started in the done cycle
      run(128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734,
          128'h3925841d02dc09fbdc118597196a0b32, 1'b0);
      run(128'h00000000000000000000000000000000, 128'h00000000000000000000000000000000,
          128'h66e94bd4ef8a2c3b884cfa59ca342b2e, 1'b0);
      run(128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h6bc1bee22e409f96e93d7e117393172a,
          128'h3ad77bb40d7a3660a89ecaf32466ef97, 1'b0);
      @(negedge clk);
      chk(dones == 4, "R8 back-to-back count", 128'(dones), 128'd4);
      chk(exp_q.size() == 0, "R7 scoreboard drained", 128'(exp_q.size()), '0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule